// File: doc/BRIEF.md
# Gated Serial Signature Analyzer

This block folds a serial bit stream into a 16-bit signature, but only inside a measurement window. Four asynchronous lines enter it. An arm line opens the window, a halt line closes it, a strobe line marks when to take a bit, and a data line carries the bits. All four are brought into the system clock domain. Edges are found on the arm, halt and strobe lines, and a configuration input picks the active polarity of each.

Inside the window, every active strobe edge feeds the current data bit into a right-shifting feedback register. When the window closes, the final register value goes to `sig_out` and `sig_valid` pulses for one cycle. The output then holds until the next window closes. Two runs of the same bit stream between an arm and a halt always give the same signature, so the block suits go/no-go comparison of a known-good node against a node under test.

Top module: `sig_window_analyzer`

## Requirements
- R1: During reset and right after it, `sig_out` is 0x0000, `sig_valid` is 0 and the window is closed.
- R2: With every `cfg_*` input at 0, the arm and halt lines act on a 0-to-1 transition and the strobe line acts on a 1-to-0 transition.
- R3: Setting `cfg_arm_fall` or `cfg_halt_fall` to 1 makes that line act on 1-to-0 instead. Setting `cfg_strb_rise` to 1 makes the strobe act on 0-to-1.
- R4: On each active strobe edge inside the window, the register shifts one place toward bit 0. The new bit 15 is the data bit XOR the parity of (register AND 0x0291), so the taps are bits 0, 4, 7 and 9. For example, from 0x0000 a 1 gives 0x8000, and a 0 after that gives 0x4000.
- R5: The register is cleared to 0x0000 whenever the window opens.
- R6: Each close of an open window gives exactly one `sig_valid` pulse, one cycle long, with the final signature on `sig_out`. `sig_out` changes only in that cycle.
- R7: Strobe edges while the window is closed shift nothing, so the next window's result does not depend on them.
- R8: An arm edge in the same cycle as a strobe edge opens the window, and that strobe edge is not sampled.
- R9: A halt edge in the same cycle as a strobe edge samples that bit first and then closes the window.
- R10: An arm edge while the window is open restarts the measurement from 0x0000 and produces no `sig_valid`.
- R11: A halt edge while the window is closed produces no `sig_valid` and leaves `sig_out` unchanged.
- R12: When arm and halt edges arrive in the same cycle, the arm edge takes priority. The window is (re)opened and cleared, and no `sig_valid` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_arm_fall | input | 1 | 1: arm acts on a falling edge; 0: on a rising edge |
| cfg_halt_fall | input | 1 | 1: halt acts on a falling edge; 0: on a rising edge |
| cfg_strb_rise | input | 1 | 1: strobe acts on a rising edge; 0: on a falling edge |
| in_arm | input | 1 | Asynchronous window-open line |
| in_halt | input | 1 | Asynchronous window-close line |
| in_strb | input | 1 | Asynchronous bit-sampling line |
| in_bit | input | 1 | Asynchronous serial data line |
| sig_out | output | 16 | Last completed signature |
| sig_valid | output | 1 | One-cycle pulse when `sig_out` takes a new signature |

## Verification
The assertions check the following on every cycle:
- the shift rule on each sampled strobe edge;
- the cleared register after any arm edge, including one that coincides with a strobe;
- that `sig_valid` lasts one cycle and only follows an open window;
- that `sig_out` never moves outside a pulse.

Some properties can only be seen at the pins, so the bench scenarios cover them. These are the polarity selections, strobe and halt activity while the window is closed, and restart by a second arm edge. They also include the coincident-edge orderings and end-to-end signature values checked against a reference model of the requirements.

// File: rtl/sig_pkg.sv
// Shared constants and the feedback step for the signature analyzer.
// Assumes a right-shifting register where the new bit enters at the top.
package sig_pkg;
    localparam int SIG_W = 16;
    localparam logic [SIG_W-1:0] TAP_MASK = 16'h0291;

    // One shift of the signature register with a new data bit.
    function automatic logic [SIG_W-1:0] sig_next(input logic [SIG_W-1:0] cur,
                                                  input logic din);
        logic fb;
        fb = (^(cur & TAP_MASK)) ^ din;
        return {fb, cur[SIG_W-1:1]};
    endfunction
endpackage

// File: rtl/sig_sync.sv
// Multi-stage synchronizer for a bundle of independent asynchronous lines.
// Assumes each line is a level that stays put for at least STAGES+1 cycles.
module sig_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift each stage toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= (g == 0) ? async_in : stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sig_edge.sv
// Per-line edge detector with a selectable polarity for each line.
// Assumes synchronized inputs; a polarity change on a static line makes no edge.
module sig_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic [N-1:0] fall_sel,
    output logic [N-1:0] edge_hit
);
    logic [N-1:0] prev_q;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pol
            assign edge_hit[g] = fall_sel[g] ? (prev_q[g] & ~level[g])
                                             : (~prev_q[g] & level[g]);
        end
    endgenerate
endmodule

// File: rtl/sig_lfsr.sv
// Signature register: cleared on request, stepped with a data bit when enabled.
// Also exposes the value it would take this cycle, for latching on close.
module sig_lfsr
    import sig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step_en,
    input  logic             din,
    output logic [SIG_W-1:0] state,
    output logic [SIG_W-1:0] state_next
);
    // Value after this cycle's optional step (clear excluded).
    always_comb begin
        state_next = step_en ? sig_next(state, din) : state;
    end

    // Clear has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)     state <= '0;
        else if (clear) state <= '0;
        else            state <= state_next;
    end
endmodule

// File: rtl/sig_window_analyzer.sv
// Gated serial signature analyzer top.
// It synchronizes four lines and detects polarity-selected edges on arm, halt
// and strobe. Inside an arm..halt window it folds data bits into the signature
// and latches the result with a one-cycle valid pulse on close.
// Assumes all lines are low while reset is applied.
module sig_window_analyzer
    import sig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_arm_fall,
    input  logic             cfg_halt_fall,
    input  logic             cfg_strb_rise,
    input  logic             in_arm,
    input  logic             in_halt,
    input  logic             in_strb,
    input  logic             in_bit,
    output logic [SIG_W-1:0] sig_out,
    output logic             sig_valid
);
    localparam int N_LINES = 4;
    localparam int N_EDGES = 3;

    logic [N_LINES-1:0] lines_s;
    logic [N_EDGES-1:0] edges;
    logic               arm_edge, halt_edge, strb_edge, bit_s;
    logic               gate_q;
    logic               step_en;
    logic [SIG_W-1:0]   lfsr_q, lfsr_nx;

    sig_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({in_bit, in_strb, in_halt, in_arm}),
        .sync_out (lines_s)
    );

    sig_edge #(.N(N_EDGES)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lines_s[N_EDGES-1:0]),
        .fall_sel ({~cfg_strb_rise, cfg_halt_fall, cfg_arm_fall}),
        .edge_hit (edges)
    );

    assign arm_edge  = edges[0];
    assign halt_edge = edges[1];
    assign strb_edge = edges[2];
    assign bit_s     = lines_s[3];

    // A bit is sampled only in an open window not being restarted.
    assign step_en = gate_q & ~arm_edge & strb_edge;

    sig_lfsr lfsr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (arm_edge),
        .step_en    (step_en),
        .din        (bit_s),
        .state      (lfsr_q),
        .state_next (lfsr_nx)
    );

    // Window state: arm opens (or restarts), halt closes an open window.
    always_ff @(posedge clk) begin
        if (!rst_n)                   gate_q <= 1'b0;
        else if (arm_edge)            gate_q <= 1'b1;
        else if (gate_q && halt_edge) gate_q <= 1'b0;
    end

    // Result latch and one-cycle valid pulse on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_out   <= '0;
            sig_valid <= 1'b0;
        end else begin
            sig_valid <= 1'b0;
            if (!arm_edge && gate_q && halt_edge) begin
                sig_out   <= lfsr_nx;
                sig_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sig_window_chk.sv
// Property checker for the signature analyzer, bound to the top.
module sig_window_chk
    import sig_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sig_valid,
    input logic [SIG_W-1:0] sig_out,
    input logic             gate_q,
    input logic [SIG_W-1:0] lfsr_q,
    input logic             arm_edge,
    input logic             strb_edge,
    input logic             bit_s
);
    // R4
    shift_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !arm_edge && strb_edge) |=> lfsr_q == sig_next($past(lfsr_q), $past(bit_s)));

    // R5
    open_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_edge |=> (gate_q && lfsr_q == '0));

    // R8
    arm_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_edge && strb_edge) |=> lfsr_q == '0);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |=> !sig_valid);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_valid |-> $stable(sig_out));

    // R11
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |-> ($past(gate_q) && !gate_q));
endmodule

bind sig_window_analyzer sig_window_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_valid (sig_valid),
    .sig_out   (sig_out),
    .gate_q    (gate_q),
    .lfsr_q    (lfsr_q),
    .arm_edge  (arm_edge),
    .strb_edge (strb_edge),
    .bit_s     (bit_s)
);

// File: tb/sig_window_analyzer_tb_top.sv
`timescale 1ns/1ps
module sig_window_analyzer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_arm_fall = 1'b0, cfg_halt_fall = 1'b0, cfg_strb_rise = 1'b0;
    logic        in_arm = 1'b0, in_halt = 1'b0, in_strb = 1'b0, in_bit = 1'b0;
    logic [15:0] sig_out;
    logic        sig_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state (requirement level).
    logic        m_gate = 1'b0;
    logic [15:0] m_reg = '0;
    logic [15:0] m_sig = '0;
    int          m_pulses;
    int          got_pulses;

    always #10 clk = ~clk;

    sig_window_analyzer dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_arm_fall(cfg_arm_fall), .cfg_halt_fall(cfg_halt_fall),
        .cfg_strb_rise(cfg_strb_rise),
        .in_arm(in_arm), .in_halt(in_halt), .in_strb(in_strb), .in_bit(in_bit),
        .sig_out(sig_out), .sig_valid(sig_valid)
    );

    function automatic logic [15:0] ref_step(input logic [15:0] r, input logic d);
        logic p;
        p = r[0] ^ r[4] ^ r[7] ^ r[9] ^ d;
        return {p, r[15:1]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive new line levels at a falling clock edge, update the model, and let
    // the change pass through the sync and edge stages while counting pulses.
    task automatic apply(input logic a, input logic h, input logic s, input logic d);
        logic ae, he, se;
        ae = cfg_arm_fall  ? (in_arm  & ~a) : (~in_arm  & a);
        he = cfg_halt_fall ? (in_halt & ~h) : (~in_halt & h);
        se = cfg_strb_rise ? (~in_strb & s) : (in_strb & ~s);
        m_pulses = 0;
        if (ae) begin
            m_gate = 1'b1;
            m_reg  = '0;
        end else if (m_gate) begin
            if (se) m_reg = ref_step(m_reg, d);
            if (he) begin
                m_gate   = 1'b0;
                m_sig    = m_reg;
                m_pulses = 1;
            end
        end
        in_arm = a; in_halt = h; in_strb = s; in_bit = d;
        got_pulses = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (sig_valid) got_pulses++;
        end
    endtask

    task automatic expect_result(input string tag);
        chk(got_pulses == m_pulses, {tag, " pulse count"}, got_pulses, m_pulses);
        chk(sig_out == m_sig, {tag, " signature"}, sig_out, m_sig);
    endtask

    // Feed one bit with a full strobe cycle in the default falling polarity.
    task automatic shift_bit_def(input logic d);
        apply(in_arm, in_halt, 1'b1, d);
        apply(in_arm, in_halt, 1'b0, d);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sig_out == 16'h0 && sig_valid == 1'b0, "R1 reset", {15'd0, sig_valid, sig_out}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sig_out == 16'h0 && sig_valid == 1'b0, "R1 after reset", {15'd0, sig_valid, sig_out}, 0);

        // R2 R4: default polarities, single 1 then a 0
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        shift_bit_def(1'b1);
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        chk(sig_out == 16'h8000, "R4 first bit", sig_out, 16'h8000);
        chk(got_pulses == 1, "R2 valid on close", got_pulses, 1);
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        shift_bit_def(1'b1);
        shift_bit_def(1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        chk(sig_out == 16'h4000, "R4 second bit", sig_out, 16'h4000);
        chk(got_pulses == 1, "R6 one pulse", got_pulses, 1);

        // R7: strobes with the window closed
        for (int k = 0; k < 4; k++) shift_bit_def(1'b1);
        chk(got_pulses == 0 && sig_out == 16'h4000, "R7 closed strobes", sig_out, 16'h4000);
        // R11: halt edge while closed
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        expect_result("R11 halt closed");  // model was opened by nothing: closed
        // R5 R7: reopen, one 1 bit gives 0x8000 despite earlier closed strobes
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        shift_bit_def(1'b1);
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        chk(sig_out == 16'h8000, "R5 cleared at open", sig_out, 16'h8000);

        // R8: arm and strobe together, data 1 not sampled
        apply(1'b0, 1'b0, 1'b1, 1'b1);
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        chk(sig_out == 16'h0000, "R8 arm+strobe", sig_out, 16'h0000);

        // R9: halt and strobe together, bit sampled
        apply(1'b0, 1'b0, 1'b1, 1'b1);
        apply(1'b1, 1'b0, 1'b1, 1'b1);
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        chk(sig_out == 16'h8000 && got_pulses == 1, "R9 halt+strobe", sig_out, 16'h8000);

        // R10: restart while open
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        shift_bit_def(1'b1);
        shift_bit_def(1'b1);
        apply(1'b0, 1'b0, 1'b0, 1'b1);
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        chk(got_pulses == 0, "R10 no pulse on restart", got_pulses, 0);
        shift_bit_def(1'b1);
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        chk(sig_out == 16'h8000, "R10 restart", sig_out, 16'h8000);

        // R12: arm and halt together while open
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        shift_bit_def(1'b1);
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        chk(got_pulses == 0, "R12 arm wins", got_pulses, 0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        chk(sig_out == 16'h0000 && got_pulses == 1, "R12 cleared", sig_out, 16'h0000);

        // R3: inverted polarities; lines now sit at their idle-for-new-edge levels
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        cfg_arm_fall = 1'b1; cfg_halt_fall = 1'b1; cfg_strb_rise = 1'b1;
        repeat (4) @(negedge clk);
        apply(1'b0, 1'b1, 1'b0, 1'b0);          // arm falls: open
        apply(1'b0, 1'b1, 1'b1, 1'b1);          // strobe rises: bit 1
        apply(1'b0, 1'b1, 1'b0, 1'b1);          // strobe falls: ignored
        apply(1'b0, 1'b0, 1'b0, 1'b1);          // halt falls: close
        chk(sig_out == 16'h8000 && got_pulses == 1, "R3 inverted", sig_out, 16'h8000);

        // R4 R6: constrained random mix, fixed seed
        void'($urandom(32'h5A17));
        for (int n = 0; n < 400; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            if (n % 50 == 0) begin
                cfg_arm_fall  = 1'($urandom);
                cfg_halt_fall = 1'($urandom);
                cfg_strb_rise = 1'($urandom);
                repeat (2) @(negedge clk);
            end
            apply(in_arm ^ (r[0] & r[1] & r[2]), in_halt ^ (r[1] & ~r[0] & r[3]),
                  in_strb ^ r[2], 1'($urandom));
            expect_result("R4 R6 random");
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule